// File: doc/BRIEF.md
# Power-Bus Arbiter Command Channel Register Block

This block is the register-facing side of a power-management serial bus arbiter. It holds a group of independent command channels. Each channel sits in its own fixed-size window of a small register space. A host fills in up to eight bytes of outgoing data and then writes a command word. The block decodes that word into an opcode, a target slave ID, a 16-bit register address and a byte count. It presents the result to a back-end bus engine on a request/response handshake. When the engine answers, the block records the outcome as a completion flag with three error qualifiers and captures any returned read data.

Each channel tracks its own transaction. Several channels can wait for the engine at the same time, and a single request port is shared between them. A version register and an interrupt-enable register sit in a separate configuration area at the bottom of the address space. The host bus is a plain valid/write/address/data interface with a registered read return one cycle later.

Top module: `pwrbus_cmd_regs`

## Requirements
- R1: After reset, every channel register and the interrupt-enable register read zero, the version register reads the VERSION parameter, and no request is presented.
- R2: Reads return data one cycle after the access. Channel c occupies 0x800+0x80*c for c below NUM_CH, with command at +0x00, config at +0x04, status at +0x08, write-data low/high at +0x10/+0x14 and read-data low/high at +0x18/+0x1C. Version is at 0x000 and interrupt enable at 0x004. Any other address, including windows at or beyond NUM_CH, reads zero and ignores writes.
- R3: A command write to an idle channel stores the word, clears the status to zero and issues exactly one request. The request carries opcode = word[31:27], slave ID = word[23:20], register address = word[19:4], count-minus-one = word[2:0], and the 64-bit write data {high word, low word}, with byte 0 in bits [7:0].
- R4: Status bit 0 is DONE, bit 1 FAILURE, bit 2 DENIED and bit 3 DROPPED. They change only on a response or a command start. A qualifier is never set without DONE. Response error input bit 0 maps to FAILURE, bit 1 to DENIED and bit 2 to DROPPED.
- R5: For the read opcodes 1, 8, 13 and 15, the response data is stored in the read-data registers on the same edge that sets DONE, with bytes above the count forced to zero. Other opcodes leave the read data unchanged.
- R6: A command write to a channel whose transaction is in progress does not change the stored command and issues no request. The ongoing transaction then completes with both DONE and DROPPED set.
- R7: When several channels wait, the request goes to the lowest-numbered one. While the request is not accepted, the presented channel and fields stay unchanged.
- R8: The interrupt-enable and config registers read back what was last written to them. Writes to the version register have no effect.
- R9: A response addressed to a channel that is not awaiting one changes nothing in that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| reg_rdata | output | 32 | Read data |
| req_valid | output | 1 | Request presented to the back end |
| req_ready | input | 1 | Back end accepts the request |
| req_chan | output | IDX_W | Channel owning the request |
| req_opcode | output | 5 | Arbiter opcode |
| req_sid | output | 4 | Slave ID |
| req_raddr | output | 16 | Slave register address |
| req_count | output | 3 | Byte count minus one |
| req_wdata | output | 64 | Outgoing data bytes |
| rsp_valid | input | 1 | Back-end response strobe |
| rsp_chan | input | IDX_W | Channel the response belongs to |
| rsp_err | input | 3 | Error flags: [0] failed, [1] denied, [2] dropped |
| rsp_rdata | input | 64 | Returned data bytes |

## Verification
The bench uses the default build: six channels, 128-byte windows and a 12-bit address. With these values the top channel window at 0xA80 is reachable, and so is the first window past the end at 0xB00, which must read as unmapped. The 3-bit channel index also has spare codes that must never be granted. Six channels are enough to hold three requests waiting at once behind a stalled back end. The bench checks that the lowest one wins after a held, higher-numbered choice has been released.

// File: rtl/pwrbus_cmd_pkg.sv
package pwrbus_cmd_pkg;
  localparam int REG_W   = 32;
  localparam int XFER_W  = 2 * REG_W;
  localparam int NBYTES  = XFER_W / 8;
  localparam int OPC_W   = 5;
  localparam int SID_W   = 4;
  localparam int RADR_W  = 16;
  localparam int CNT_W   = 3;

  // status bit positions
  localparam int ST_DONE = 0;
  localparam int ST_FAIL = 1;
  localparam int ST_DENY = 2;
  localparam int ST_DROP = 3;

  // window offsets
  localparam int OFS_CMD = 'h00;
  localparam int OFS_CFG = 'h04;
  localparam int OFS_ST  = 'h08;
  localparam int OFS_WLO = 'h10;
  localparam int OFS_WHI = 'h14;
  localparam int OFS_RLO = 'h18;
  localparam int OFS_RHI = 'h1C;

  // configuration area
  localparam int CFG_VER = 'h000;
  localparam int CFG_IEN = 'h004;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [SID_W-1:0]  sid;
    logic [RADR_W-1:0] radr;
    logic [CNT_W-1:0]  cnt;
  } xfer_cmd_t;

  function automatic xfer_cmd_t unpack_cmd(input logic [REG_W-1:0] w);
    xfer_cmd_t r;
    r.opc  = w[31:27];
    r.sid  = w[23:20];
    r.radr = w[19:4];
    r.cnt  = w[2:0];
    return r;
  endfunction

  function automatic logic op_returns_data(input logic [OPC_W-1:0] opc);
    logic r;
    case (opc)
      5'd1, 5'd8, 5'd13, 5'd15: r = 1'b1;
      default:                  r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic [XFER_W-1:0] lane_mask(input logic [CNT_W-1:0] cnt);
    logic [XFER_W-1:0] m;
    m = '0;
    for (int b = 0; b < NBYTES; b++)
      if (b <= int'(cnt)) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction
endpackage

// File: rtl/pwrbus_req_arb.sv
module pwrbus_req_arb #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  want,
  input  logic          ready,
  output logic          valid,
  output logic [IW-1:0] sel,
  output logic [N-1:0]  grant
);
  logic          hold_q;
  logic [IW-1:0] held_q;
  logic [IW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--)
      if (want[i]) pick = IW'(i);
  end

  assign valid = |want;
  assign sel   = hold_q ? held_q : pick;

  for (genvar g = 0; g < N; g++) begin : g_grant
    assign grant[g] = valid && ready && (sel == IW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      held_q <= '0;
    end else begin
      hold_q <= valid && !ready;
      held_q <= sel;
    end
  end

  // R7
  held_choice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && sel == $past(sel)));

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R7
  grant_wanted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> (|(grant & want)));
endmodule

// File: rtl/pwrbus_chan.sv
module pwrbus_chan
  import pwrbus_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              cfg_we,
  input  logic              wlo_we,
  input  logic              whi_we,
  input  logic [REG_W-1:0]  wr_word,
  input  logic              granted,
  input  logic              rsp_hit,
  input  logic [2:0]        rsp_err,
  input  logic [XFER_W-1:0] rsp_data,
  output logic              want,
  output logic [REG_W-1:0]  cmd_word,
  output logic [REG_W-1:0]  cfg_word,
  output logic [3:0]        status,
  output logic [XFER_W-1:0] wr_data,
  output logic [XFER_W-1:0] rd_data
);
  logic      busy;
  logic      lost_q;
  xfer_cmd_t cur;

  // named events for the checks
  logic cmd_taken, cmd_lost, rsp_taken;
  assign cmd_taken = cmd_we && !busy;
  assign cmd_lost  = cmd_we && busy;
  assign rsp_taken = rsp_hit && busy && !want;
  assign cur       = unpack_cmd(cmd_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      want     <= 1'b0;
      lost_q   <= 1'b0;
      cmd_word <= '0;
      cfg_word <= '0;
      status   <= '0;
      wr_data  <= '0;
      rd_data  <= '0;
    end else begin
      if (wlo_we) wr_data[REG_W-1:0]      <= wr_word;
      if (whi_we) wr_data[XFER_W-1:REG_W] <= wr_word;
      if (cfg_we) cfg_word <= wr_word;
      if (granted) want <= 1'b0;
      if (rsp_taken) begin
        busy            <= 1'b0;
        lost_q          <= 1'b0;
        status[ST_DONE] <= 1'b1;
        status[ST_FAIL] <= rsp_err[0];
        status[ST_DENY] <= rsp_err[1];
        status[ST_DROP] <= rsp_err[2] | lost_q;
        if (op_returns_data(cur.opc))
          rd_data <= rsp_data & lane_mask(cur.cnt);
      end
      if (cmd_taken) begin
        cmd_word <= wr_word;
        status   <= '0;
        busy     <= 1'b1;
        want     <= 1'b1;
        lost_q   <= 1'b0;
      end
      if (cmd_lost) lost_q <= 1'b1;
    end
  end

  // R4
  qual_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3:1] != 3'b000) |-> status[ST_DONE]);

  // R3
  start_clears_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (status == 4'b0000 && want));

  // R6
  busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_lost && !rsp_taken) |=> (busy && $stable(cmd_word)));

  // R9
  stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !rsp_taken && !cmd_we) |=> ($stable(status) && $stable(rd_data)));
endmodule

// File: rtl/pwrbus_cmd_regs.sv
module pwrbus_cmd_regs
  import pwrbus_cmd_pkg::*;
#(
  parameter int           NUM_CH  = 6,
  parameter int           ADDR_W  = 12,
  parameter int           CH_BASE = 'h800,
  parameter int           WIN_LG  = 7,
  parameter logic [31:0]  VERSION = 32'h0002_0001,
  localparam int          IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              reg_rvalid,
  output logic [31:0]       reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [IDX_W-1:0]  req_chan,
  output logic [4:0]        req_opcode,
  output logic [3:0]        req_sid,
  output logic [15:0]       req_raddr,
  output logic [2:0]        req_count,
  output logic [63:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [IDX_W-1:0]  rsp_chan,
  input  logic [2:0]        rsp_err,
  input  logic [63:0]       rsp_rdata
);
  localparam int WIN_SIZE = 1 << WIN_LG;
  localparam int CH_END   = CH_BASE + NUM_CH * WIN_SIZE;

  // address decode
  logic              win_hit;
  logic [ADDR_W-1:0] win_rel;
  logic [IDX_W-1:0]  win_idx;
  logic [WIN_LG-1:0] win_off;
  logic              wr_any;
  logic              rd_any;

  assign win_hit = (int'(reg_addr) >= CH_BASE) && (int'(reg_addr) < CH_END);
  assign win_rel = reg_addr - ADDR_W'(CH_BASE);
  assign win_idx = IDX_W'(win_rel >> WIN_LG);
  assign win_off = win_rel[WIN_LG-1:0];
  assign wr_any  = reg_valid && reg_write;
  assign rd_any  = reg_valid && !reg_write;

  // channel array
  logic [NUM_CH-1:0] ch_want;
  logic [NUM_CH-1:0] ch_grant;
  logic [REG_W-1:0]  ch_cmd [NUM_CH];
  logic [REG_W-1:0]  ch_cfg [NUM_CH];
  logic [3:0]        ch_st  [NUM_CH];
  logic [XFER_W-1:0] ch_wd  [NUM_CH];
  logic [XFER_W-1:0] ch_rd  [NUM_CH];
  logic [IDX_W-1:0]  arb_sel;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit_c;
    assign hit_c = wr_any && win_hit && (win_idx == IDX_W'(c));
    pwrbus_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (hit_c && win_off == WIN_LG'(OFS_CMD)),
      .cfg_we   (hit_c && win_off == WIN_LG'(OFS_CFG)),
      .wlo_we   (hit_c && win_off == WIN_LG'(OFS_WLO)),
      .whi_we   (hit_c && win_off == WIN_LG'(OFS_WHI)),
      .wr_word  (reg_wdata),
      .granted  (ch_grant[c]),
      .rsp_hit  (rsp_valid && rsp_chan == IDX_W'(c)),
      .rsp_err  (rsp_err),
      .rsp_data (rsp_rdata),
      .want     (ch_want[c]),
      .cmd_word (ch_cmd[c]),
      .cfg_word (ch_cfg[c]),
      .status   (ch_st[c]),
      .wr_data  (ch_wd[c]),
      .rd_data  (ch_rd[c])
    );
  end

  pwrbus_req_arb #(.N(NUM_CH), .IW(IDX_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .want  (ch_want),
    .ready (req_ready),
    .valid (req_valid),
    .sel   (arb_sel),
    .grant (ch_grant)
  );

  // request field mux
  xfer_cmd_t         pick_cmd;
  logic [XFER_W-1:0] pick_wd;
  always_comb begin
    pick_cmd = '0;
    pick_wd  = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (arb_sel == IDX_W'(c)) begin
        pick_cmd = unpack_cmd(ch_cmd[c]);
        pick_wd  = ch_wd[c];
      end
  end

  assign req_chan   = arb_sel;
  assign req_opcode = pick_cmd.opc;
  assign req_sid    = pick_cmd.sid;
  assign req_raddr  = pick_cmd.radr;
  assign req_count  = pick_cmd.cnt;
  assign req_wdata  = pick_wd;

  // configuration area
  logic [REG_W-1:0] ien_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ien_q <= '0;
    else if (wr_any && !win_hit && reg_addr == ADDR_W'(CFG_IEN)) ien_q <= reg_wdata;
  end

  // read mux
  logic [REG_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (!win_hit) begin
      if (reg_addr == ADDR_W'(CFG_VER))      rd_next = VERSION;
      else if (reg_addr == ADDR_W'(CFG_IEN)) rd_next = ien_q;
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        if (win_idx == IDX_W'(c)) begin
          case (win_off)
            WIN_LG'(OFS_CMD): rd_next = ch_cmd[c];
            WIN_LG'(OFS_CFG): rd_next = ch_cfg[c];
            WIN_LG'(OFS_ST):  rd_next = {{(REG_W-4){1'b0}}, ch_st[c]};
            WIN_LG'(OFS_WLO): rd_next = ch_wd[c][REG_W-1:0];
            WIN_LG'(OFS_WHI): rd_next = ch_wd[c][XFER_W-1:REG_W];
            WIN_LG'(OFS_RLO): rd_next = ch_rd[c][REG_W-1:0];
            WIN_LG'(OFS_RHI): rd_next = ch_rd[c][XFER_W-1:REG_W];
            default:          rd_next = '0;
          endcase
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= rd_any;
      reg_rdata  <= rd_any ? rd_next : '0;
    end
  end

  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> reg_rvalid);

  // R2
  no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> !reg_rvalid);

  // R7
  req_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_chan) < NUM_CH));
endmodule

// File: tb/test_pwrbus_cmd_regs.sv
module test_pwrbus_cmd_regs;
  localparam logic [31:0] VER = 32'h0002_0001;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rvalid;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [2:0]  req_chan;
  logic [4:0]  req_opcode;
  logic [3:0]  req_sid;
  logic [15:0] req_raddr;
  logic [2:0]  req_count;
  logic [63:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [2:0]  rsp_chan = '0;
  logic [2:0]  rsp_err = '0;
  logic [63:0] rsp_rdata = '0;

  always #2 clk = ~clk;

  pwrbus_cmd_regs i_pwrbus_cmd_regs (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
    .reg_rdata(reg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_opcode(req_opcode), .req_sid(req_sid),
    .req_raddr(req_raddr), .req_count(req_count), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_chan(rsp_chan), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit          m_busy [NCH];
  bit          m_pend [NCH];
  bit          m_drop [NCH];
  logic [31:0] m_cmd  [NCH];
  logic [31:0] m_cfg  [NCH];
  logic [3:0]  m_st   [NCH];
  logic [63:0] m_wd   [NCH];
  logic [63:0] m_rd   [NCH];
  logic [31:0] m_ien;
  bit          m_hold;
  int          m_hsel;
  bit          m_rv;
  logic [31:0] m_rexp;
  string       m_rtag = "R2";
  string       cur_tag = "R2";

  function automatic int m_pick();
    if (m_hold) return m_hsel;
    for (int c = 0; c < NCH; c++) if (m_pend[c]) return c;
    return -1;
  endfunction

  function automatic bit win_of(input logic [11:0] a, output int c, output int o);
    int v;
    v = int'(a);
    if (v < 'h800 || v >= 'h800 + NCH * 128) return 1'b0;
    c = (v - 'h800) / 128;
    o = (v - 'h800) % 128;
    return 1'b1;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int c, o;
    if (!win_of(a, c, o)) begin
      if (a == 12'h000) return VER;
      if (a == 12'h004) return m_ien;
      return 32'h0;
    end
    case (o)
      'h00: return m_cmd[c];
      'h04: return m_cfg[c];
      'h08: return {28'h0, m_st[c]};
      'h10: return m_wd[c][31:0];
      'h14: return m_wd[c][63:32];
      'h18: return m_rd[c][31:0];
      'h1C: return m_rd[c][63:32];
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit reads_back(input logic [4:0] op);
    return op == 5'd1 || op == 5'd8 || op == 5'd13 || op == 5'd15;
  endfunction

  always @(posedge clk) begin
    int s, c, o;
    if (!rst_n) begin
      for (int k = 0; k < NCH; k++) begin
        m_busy[k] = 0; m_pend[k] = 0; m_drop[k] = 0;
        m_cmd[k] = '0; m_cfg[k] = '0; m_st[k] = '0; m_wd[k] = '0; m_rd[k] = '0;
      end
      m_ien = '0; m_hold = 0; m_hsel = 0; m_rv = 0; m_rexp = '0;
    end else begin
      s = m_pick();
      m_rv = reg_valid && !reg_write;
      if (m_rv) begin
        m_rexp = m_read(reg_addr);
        m_rtag = cur_tag;
      end
      if (reg_valid && reg_write) begin
        if (win_of(reg_addr, c, o)) begin
          case (o)
            'h00: if (m_busy[c]) m_drop[c] = 1;
                  else begin
                    m_cmd[c] = reg_wdata; m_st[c] = 4'h0;
                    m_busy[c] = 1; m_pend[c] = 1; m_drop[c] = 0;
                  end
            'h04: m_cfg[c] = reg_wdata;
            'h10: m_wd[c][31:0] = reg_wdata;
            'h14: m_wd[c][63:32] = reg_wdata;
            default: ;
          endcase
        end else if (reg_addr == 12'h004) m_ien = reg_wdata;
      end
      if (rsp_valid && m_busy[rsp_chan] && !m_pend[rsp_chan]) begin
        c = int'(rsp_chan);
        m_st[c] = {m_drop[c] | rsp_err[2], rsp_err[1], rsp_err[0], 1'b1};
        if (reads_back(m_cmd[c][31:27]))
          m_rd[c] = (m_cmd[c][2:0] == 3'd7) ? rsp_rdata
                  : rsp_rdata & ((64'h1 << (8 * (int'(m_cmd[c][2:0]) + 1))) - 64'h1);
        m_busy[c] = 0; m_drop[c] = 0;
      end
      if (s >= 0) begin
        if (req_ready) begin m_pend[s] = 0; m_hold = 0; end
        else begin m_hold = 1; m_hsel = s; end
      end else m_hold = 0;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    int s;
    if (rst_n && !finished) begin
      s = m_pick();
      check(req_valid === (s >= 0), "R7 req_valid", {63'h0, req_valid}, {63'h0, s >= 0});
      if (s >= 0) begin
        check(req_chan === 3'(s), "R7 req_chan", {61'h0, req_chan}, 64'(s));
        check({req_opcode, req_sid, req_raddr, req_count} ===
              {m_cmd[s][31:27], m_cmd[s][23:20], m_cmd[s][19:4], m_cmd[s][2:0]},
              "R3 req fields", {36'h0, req_opcode, req_sid, req_raddr, req_count},
              {36'h0, m_cmd[s][31:27], m_cmd[s][23:20], m_cmd[s][19:4], m_cmd[s][2:0]});
        check(req_wdata === m_wd[s], "R3 req_wdata", req_wdata, m_wd[s]);
      end
      check(reg_rvalid === m_rv, "R2 rvalid", {63'h0, reg_rvalid}, {63'h0, m_rv});
      if (m_rv) check(reg_rdata === m_rexp, m_rtag, {32'h0, reg_rdata}, {32'h0, m_rexp});
    end
  end

  // stimulus tasks
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd_expect(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cur_tag = tag;
    reg_valid = 1; reg_write = 0; reg_addr = a;
    @(negedge clk);
    reg_valid = 0;
    check(reg_rdata === exp, tag, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  task automatic respond(input int c, input logic [2:0] e, input logic [63:0] d);
    @(negedge clk);
    rsp_valid = 1; rsp_chan = 3'(c); rsp_err = e; rsp_rdata = d;
    @(negedge clk);
    rsp_valid = 0;
  endtask

  function automatic logic [31:0] mk(input int op, input int sid, input int ra, input int cnt);
    return {5'(op), 3'b000, 4'(sid), 16'(ra), 1'b0, 3'(cnt)};
  endfunction

  function automatic logic [11:0] ch(input int c, input int off);
    return 12'('h800 + 128 * c + off);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_expect(12'h000, VER, "R1 version");
    rd_expect(12'h004, 32'h0, "R1 irq enable");
    rd_expect(ch(0, 'h08), 32'h0, "R1 status");
    rd_expect(ch(5, 'h18), 32'h0, "R1 read data");
    // R8 read-back and read-only version
    wr(12'h004, 32'hA5A5_0003);
    rd_expect(12'h004, 32'hA5A5_0003, "R8 irq enable");
    wr(12'h000, 32'hFFFF_FFFF);
    rd_expect(12'h000, VER, "R8 version write ignored");
    wr(ch(2, 'h04), 32'h1357_9BDF);
    rd_expect(ch(2, 'h04), 32'h1357_9BDF, "R8 config");
    // R3 / R5 short read
    wr(ch(0, 'h10), 32'h4433_2211);
    wr(ch(0, 'h14), 32'h8877_6655);
    wr(ch(0, 'h00), mk(15, 5, 'h1234, 2));
    respond(0, 3'b000, 64'hDEAD_BEEF_CAFE_F00D);
    rd_expect(ch(0, 'h08), 32'h1, "R4 done only");
    rd_expect(ch(0, 'h18), 32'h00FE_F00D, "R5 masked low word");
    rd_expect(ch(0, 'h1C), 32'h0, "R5 masked high word");
    // R3 status cleared on start; R5 full read; R4 failure
    wr(ch(0, 'h00), mk(1, 9, 'hBEEF, 7));
    rd_expect(ch(0, 'h08), 32'h0, "R3 status cleared");
    respond(0, 3'b001, 64'hDEAD_BEEF_CAFE_F00D);
    rd_expect(ch(0, 'h08), 32'h3, "R4 failure");
    rd_expect(ch(0, 'h1C), 32'hDEAD_BEEF, "R5 eight bytes");
    // R5 write opcode leaves read data; R4 denied
    wr(ch(0, 'h00), mk(14, 3, 'h0042, 0));
    respond(0, 3'b010, 64'h1111);
    rd_expect(ch(0, 'h08), 32'h5, "R4 denied");
    rd_expect(ch(0, 'h18), 32'hCAFE_F00D, "R5 write leaves read data");
    // R6 command while busy
    wr(ch(1, 'h00), mk(2, 1, 'h0010, 1));
    wr(ch(1, 'h00), mk(16, 2, 'h0020, 0));
    rd_expect(ch(1, 'h00), mk(2, 1, 'h0010, 1), "R6 command kept");
    rd_expect(ch(1, 'h08), 32'h0, "R6 still busy");
    respond(1, 3'b000, 64'h0);
    rd_expect(ch(1, 'h08), 32'h9, "R6 dropped with done");
    // R7 arbitration with a stalled back end
    req_ready = 0;
    wr(ch(4, 'h00), mk(13, 4, 'h0400, 3));
    wr(ch(3, 'h00), mk(8, 3, 'h0300, 1));
    wr(ch(1, 'h00), mk(15, 1, 'h0100, 0));
    repeat (3) @(negedge clk);
    check(req_valid === 1'b1 && req_chan === 3'd4, "R7 held choice", {61'h0, req_chan}, 64'd4);
    req_ready = 1;
    @(negedge clk);
    check(req_chan === 3'd1, "R7 lowest next", {61'h0, req_chan}, 64'd1);
    repeat (3) @(negedge clk);
    respond(4, 3'b100, 64'h0123_4567_89AB_CDEF);
    respond(3, 3'b000, 64'hFFFF_FFFF_FFFF_FFFF);
    respond(1, 3'b000, 64'h77);
    rd_expect(ch(4, 'h08), 32'h9, "R4 dropped from engine");
    rd_expect(ch(4, 'h18), 32'h89AB_CDEF, "R5 four bytes");
    rd_expect(ch(3, 'h18), 32'h0000_FFFF, "R5 two bytes");
    rd_expect(ch(1, 'h18), 32'h0000_0077, "R5 one byte");
    // R9 stray response
    respond(5, 3'b111, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_expect(ch(5, 'h08), 32'h0, "R9 status untouched");
    rd_expect(ch(5, 'h18), 32'h0, "R9 read data untouched");
    // R2 map edges
    wr(ch(5, 'h10), 32'hABCD_0123);
    rd_expect(ch(5, 'h10), 32'hABCD_0123, "R2 last window");
    wr(12'hB00, 32'hFFFF_FFFF);
    rd_expect(12'hB00, 32'h0, "R2 window past end");
    rd_expect(12'h008, 32'h0, "R2 unmapped config");
    rd_expect(ch(2, 'h0C), 32'h0, "R2 unmapped offset");
    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule